// File: doc/BRIEF.md
# Manchester Line Decoder with Inverted-Pair Correction

This block turns an oversampled Manchester-coded serial stream back into NRZ bits. The line is sampled by the local clock at eight samples per bit cell. The decoder locks its bit timing onto the transitions at the centre of each cell and ignores the transitions at cell boundaries. It delivers each decoded bit with a one-cycle strobe and raises a carrier indication for the length of a frame.

If the twisted pair is wired with swapped legs, the decoder sees the end-of-frame signature the wrong way round. It then sets a sticky flag that reports the inverted pair. While automatic correction is enabled and the flag is set, the incoming stream is inverted before decoding, so later frames decode correctly. With correction disabled, the stream passes through unchanged and the bits come out inverted. The flag clears only on reset or on an explicit clear pulse.

Top module: `manch_rx`

## Requirements
- R1: During reset and in the first cycle after it, `rx_data_o`, `rx_valid_o`, `crs_o` and `pol_inv_o` are all 0.
- R2: Each accepted mid-cell edge delivers one bit. A low-to-high edge on the (possibly corrected) stream decodes as 1, and a high-to-low edge decodes as 0. `rx_valid_o` is high for exactly one cycle. That cycle follows the clock edge that sampled the changed line value.
- R3: A mid-cell edge is accepted when it arrives 6 to 10 samples (8 ± 2) after the previous accepted one. Edges at cell boundaries, which fall about half a cell after a mid-cell edge, are ignored. Frames whose bit cells are 6, 7, 8, 9 or 10 samples long are therefore decoded completely.
- R4: Bit timing is acquired on an alternating preamble. The first edge starts a run. Each in-window edge extends the run, and an out-of-window edge restarts it. After 8 clean cells, the next in-window edge (the 10th edge of the run) raises `crs_o`, and that edge's bit is the first one delivered. A run of 9 edges raises no carrier.
- R5: If the last accepted mid-cell edge is sampled at clock k and no further accepted edge follows, `crs_o` falls on clock k+12 (1.5 bit times).
- R6: When the carrier ends, `pol_inv_o` is set if the last accepted mid-cell edge on the raw line was high-to-low. The flag rises only together with the carrier falling and stays set while no clear is applied.
- R7: A one-cycle high on `pol_clr_i` while no frame is ending clears `pol_inv_o` on the next clock.
- R8: While `auto_pol_i` and `pol_inv_o` are both 1, the raw line is inverted before decoding, so frames from an inverted pair decode correctly. The frame that first sets the flag is still delivered inverted.
- R9: While `auto_pol_i` is 0, no inversion is applied, and a frame from an inverted pair is delivered with every bit inverted even when the flag is set.
- R10: A stream whose mid-cell edges are 5 or 11 samples apart never raises `crs_o` and delivers no bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8 per bit cell |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Sliced line sample |
| auto_pol_i | input | 1 | Enable automatic polarity correction |
| pol_clr_i | input | 1 | Clear pulse for the inverted-pair flag |
| rx_data_o | output | 1 | Decoded bit, qualified by rx_valid_o |
| rx_valid_o | output | 1 | One-cycle strobe per decoded bit |
| crs_o | output | 1 | Carrier present |
| pol_inv_o | output | 1 | Sticky inverted-pair flag |

## Verification
The assertions assume that `line_i` is already synchronous to `clk` and holds one value per sample. They also assume that `pol_clr_i` is asserted only while the carrier is low and that `auto_pol_i` changes only between frames. The stimulus follows these rules: every frame is built sample by sample on the falling clock edge. Each frame ends on a mid-cell edge that is low-to-high on the true data, followed by at least 20 quiet samples. The mode and clear inputs are changed only inside those quiet gaps.

// File: rtl/manch_rx.sv
`timescale 1ns/1ps
module manch_rx #(
  parameter int OSR       = 8,
  parameter int TOL       = 2,
  parameter int PRE_CELLS = 8
)(
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic auto_pol_i,
  input  logic pol_clr_i,
  output logic rx_data_o,
  output logic rx_valid_o,
  output logic crs_o,
  output logic pol_inv_o
);
  localparam int DROP = OSR + OSR / 2;
  localparam int CW   = $clog2(DROP + 1);
  localparam int PW   = $clog2(PRE_CELLS + 1);
  localparam logic [CW-1:0] LO_C   = CW'(OSR - TOL);
  localparam logic [CW-1:0] HI_C   = CW'(OSR + TOL);
  localparam logic [CW-1:0] DROP_C = CW'(DROP);
  localparam logic [PW-1:0] PRE_C  = PW'(PRE_CELLS);

  logic          line_q, hunt, last_dir;
  logic [CW-1:0] cnt;
  logic [PW-1:0] cells;

  wire edge_w  = line_i ^ line_q;
  wire active  = hunt | crs_o;
  wire in_win  = (cnt >= LO_C) && (cnt <= HI_C);
  wire take    = active & edge_w & in_win;
  wire restart = hunt & edge_w & ~in_win;
  wire timeout = active & ~take & ~restart & (cnt >= DROP_C);
  wire lock    = hunt & take & (cells >= PRE_C);
  wire corr    = auto_pol_i & pol_inv_o;
  wire drop_w  = crs_o & timeout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q     <= 1'b0;
      hunt       <= 1'b0;
      last_dir   <= 1'b1;
      cnt        <= '0;
      cells      <= '0;
      rx_data_o  <= 1'b0;
      rx_valid_o <= 1'b0;
      crs_o      <= 1'b0;
    end else begin
      line_q     <= line_i;
      rx_valid_o <= 1'b0;
      if (!active) begin
        if (edge_w) begin
          hunt  <= 1'b1;
          cnt   <= CW'(1);
          cells <= '0;
        end
      end else if (take) begin
        cnt      <= CW'(1);
        last_dir <= line_i;
        if (crs_o || lock) begin
          rx_valid_o <= 1'b1;
          rx_data_o  <= line_i ^ corr;
          crs_o      <= 1'b1;
          hunt       <= 1'b0;
        end else begin
          cells <= cells + 1'b1;
        end
      end else if (restart) begin
        cnt   <= CW'(1);
        cells <= '0;
      end else if (timeout) begin
        hunt  <= 1'b0;
        crs_o <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   pol_inv_o <= 1'b0;
    else if (drop_w && !last_dir) pol_inv_o <= 1'b1;
    else if (pol_clr_i)           pol_inv_o <= 1'b0;
  end

  logic [CW-1:0] gap;
  always_ff @(posedge clk) begin
    if (!rst_n || !crs_o || rx_valid_o) gap <= '0;
    else                                gap <= gap + 1'b1;
  end

  // R2
  valid_in_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> crs_o);
  // R4
  carrier_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crs_o) |-> rx_valid_o);
  // R5
  carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crs_o |-> (gap < DROP_C - CW'(1)));
  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_inv_o && !pol_clr_i) |=> pol_inv_o);
  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pol_inv_o) |-> $fell(crs_o));
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_clr_i && !crs_o) |=> !pol_inv_o);
endmodule

// File: tb/manch_rx_tb_top.sv
`timescale 1ns/1ps
module manch_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, line = 1'b0, auto_pol = 1'b1, pol_clr = 1'b0;
  logic rx_data, rx_valid, crs, pol_inv;
  int tests = 0, fails = 0, cyc = 0, lchg = 0;
  int ngot = 0, bad_tim = 0, gap_seen = -1;
  bit crs_seen = 0, crs_prev = 0, pol_model = 0;
  bit got [0:127];
  bit fb  [0:127];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  manch_rx dut_i (.clk(clk), .rst_n(rst_n), .line_i(line), .auto_pol_i(auto_pol),
    .pol_clr_i(pol_clr), .rx_data_o(rx_data), .rx_valid_o(rx_valid), .crs_o(crs),
    .pol_inv_o(pol_inv));

  always @(negedge clk) begin
    if (rx_valid) begin
      if (ngot < 128) got[ngot] = rx_data;
      ngot++;
      if (lchg != cyc) bad_tim++;
    end
    if (crs_prev && !crs) gap_seen = cyc - lchg;
    if (crs) crs_seen = 1;
    crs_prev = crs;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic samp(input bit v);
    @(negedge clk);
    if (v != line) lchg <= cyc + 1;
    line <= v;
  endtask

  function automatic int fill(input int pat, input int pay);
    bit [7:0] lf = 8'hA7;
    for (int i = 0; i < 10; i++) fb[i] = ~i[0];
    for (int i = 0; i < pay; i++) begin
      case (pat)
        0: fb[10+i] = 1'b1;
        1: fb[10+i] = 1'b0;
        2: begin fb[10+i] = lf[0]; lf = {lf[6:0], lf[7]^lf[5]^lf[4]^lf[3]}; end
        default: fb[10+i] = i[0];
      endcase
    end
    fb[10+pay] = 1'b1;
    return 11 + pay;
  endfunction

  task automatic run_frame(input int n, input int cl, input bit inv, input bit au,
                           input string dtag);
    bit locked, corr, rb;
    int err;
    @(negedge clk); auto_pol <= au;
    corr = au & pol_model;
    @(posedge clk); #1;
    ngot = 0; bad_tim = 0; gap_seen = -1; crs_seen = 0;
    for (int i = 0; i < n; i++) begin
      rb = fb[i] ^ inv;
      repeat (cl / 2) samp(~rb);
      repeat (cl - cl / 2) samp(rb);
    end
    repeat (20) samp(line);
    @(negedge clk);
    locked = (n >= 10) && (cl >= 6) && (cl <= 10);
    if (locked) begin
      err = 0;
      for (int k = 0; k < ngot && k < 128; k++)
        if (got[k] != (fb[k+9] ^ inv ^ corr)) err++;
      chk(ngot == n - 9, "R4", ngot, n - 9);
      chk(err == 0, dtag, err, 0);
      chk(bad_tim == 0, "R2", bad_tim, 0);
      chk(gap_seen == 12, "R5", gap_seen, 12);
      pol_model = pol_model | inv;
    end else begin
      chk(!crs_seen && ngot == 0, (cl == 8) ? "R4" : "R10", ngot, 0);
    end
    chk(pol_inv == pol_model, "R6", pol_inv, pol_model);
  endtask

  task automatic clear_flag();
    @(negedge clk); pol_clr <= 1'b1;
    @(negedge clk); pol_clr <= 1'b0;
    @(negedge clk);
    pol_model = 0;
    chk(pol_inv == 1'b0, "R7", pol_inv, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk({rx_data, rx_valid, crs, pol_inv} == 4'b0, "R1", {rx_data, rx_valid, crs, pol_inv}, 0);
    rst_n <= 1'b1;
    @(negedge clk);
    chk({rx_data, rx_valid, crs, pol_inv} == 4'b0, "R1", {rx_data, rx_valid, crs, pol_inv}, 0);

    // R3: sweep of cell length and payload pattern
    for (int cl = 6; cl <= 10; cl++)
      for (int pat = 0; pat < 4; pat++) begin
        n = fill(pat, 24);
        run_frame(n, cl, 1'b0, 1'b1, "R3");
      end

    // R10: cell spacing outside the window
    n = fill(3, 20);
    run_frame(n, 5, 1'b0, 1'b1, "R10");
    run_frame(n, 11, 1'b0, 1'b1, "R10");

    // R4: preamble boundary, 9 edges then 11 edges
    n = fill(3, 0);
    run_frame(9, 8, 1'b0, 1'b1, "R4");
    run_frame(11, 8, 1'b0, 1'b1, "R4");

    // R8: inverted pair with auto-correction
    n = fill(2, 30);
    run_frame(n, 8, 1'b1, 1'b1, "R8");
    run_frame(n, 8, 1'b1, 1'b1, "R8");
    run_frame(n, 9, 1'b0, 1'b1, "R8");
    clear_flag();

    // R9: inverted pair with correction disabled
    run_frame(n, 8, 1'b1, 1'b0, "R9");
    run_frame(n, 7, 1'b1, 1'b0, "R9");
    clear_flag();
    run_frame(n, 8, 1'b0, 1'b1, "R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #3000000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule